// File: doc/BRIEF.md
# Buffered SPI Command Master

This block is a register-mapped SPI master. Software sets up a configuration word, loads up to nine bytes into a small byte buffer, and then writes a command word. The block runs that command as one shift sequence on one of four chip-select lines.

A command says how many bytes to clock in total and how many of the leading bytes are driven from the buffer. The remaining bytes are receive-only. Every byte clocked in is written back over the buffer slot it came from, so software reads its results from the same addresses it filled.

A status bit reports that a command is running. A command can leave its chip select asserted, so that the next command continues the same frame. The clock rate, the idle level of the clock, the sample phase, the bit order, the chip-select polarity and a single-wire shared-data mode all come from the configuration word.

Top module: `spi_buf_master`

## Requirements
- R1: Register decode on the 8-bit byte address:
  - 0x00 is the configuration word and reads back its defined fields.
  - 0x08 is status, with the busy flag in bit 0.
  - 0x10 is the command word.
  - Buffer slot i (0..8) sits at 0x80+8*i and reads back its byte in bits 7:0.
  - Any other address reads zero.
- R2: Busy is set on the clock edge that accepts a command write and stays set for exactly 16*D*N clock cycles. D is the divider in configuration bits 28:16, with a value of 0 used as 1. N is the effective byte count.
- R3: Command layout: bits 1:0 select the chip select, bit 2 is the leave-asserted flag, bits 7:4 are the transmit count and bits 11:8 are the total count. The first transmit-count bytes are shifted out from buffer slots 0 upward. Configuration bit 1 selects LSB-first; when it is clear, bytes go MSB-first. In four-wire mode the receive-only bytes drive the data output low.
- R4: The byte received as the i-th byte of a command is written into buffer slot i, assembled in the same bit order as the transmit bytes.
- R5: Idle and phase:
  - SCLK idles high, or low when configuration bit 3 is set.
  - With configuration bit 4 clear, each bit cell starts at the idle level and turns active at mid-cell.
  - With bit 4 set, each cell starts active and returns to idle at mid-cell.
  - Input data is sampled at the mid-cell transition in both cases.
- R6: Chip-select assertion:
  - The selected chip select is at its active level for the whole command. The active level is low, or high when configuration bit 0 is set.
  - When the command ends it goes back to inactive, unless the leave-asserted flag was set. In that case it stays active until a later command ends without that flag.
  - At most one chip select is active at a time.
- R7: Chip-select output enables follow configuration bits 15:12, one bit per line. Writing zero to the configuration register turns every enable off and drops any held chip select.
- R8: Three-wire mode (configuration bit 2):
  - The data output enable is high only during the transmit bytes of a running command.
  - Received bits are taken from the shared-line input, not from the four-wire input.
- R9: While busy, writes to the command, the configuration and the buffer slots are ignored.
- R10: Count limits:
  - A total count above 9 is reduced to 9.
  - A transmit count above the total is reduced to the total.
  - A command with total count 0 does not start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_dout | output | 1 | Serial data out (shared line in three-wire mode) |
| spi_dout_en | output | 1 | Output enable for spi_dout |
| spi_din | input | 1 | Serial data in, four-wire mode |
| spi_dio_in | input | 1 | Shared data line input, three-wire mode |
| spi_cs_o | output | 4 | Chip-select levels |
| spi_cs_oe | output | 4 | Chip-select output enables |

## Verification
The bench goes after several boundary cases:
- Split commands, where only part of the bytes are transmitted. A design that mixed up the two counts would drive buffer data during the receive-only bytes.
- The sample point in both phase settings. A slip there shows up as received bytes shifted by one bit.
- Divider zero and count clamping. A wrong choice here changes the measured busy length or the number of clock pulses.
- Holding the chip select across commands, followed by clearing it with a zero configuration write. A design that lost or kept the hold wrongly would leave the line at the wrong level.
- Writes landing mid-command. A design that accepted them would restart, stretch the busy window or corrupt a buffer slot.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;

    localparam int NBYTES = 9;
    localparam int NCS    = 4;
    localparam int CS_W   = $clog2(NCS);
    localparam int DIV_W  = 13;
    localparam int CNT_W  = $clog2(NBYTES + 1);
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CFG  = 8'h00;
    localparam logic [ADDR_W-1:0] A_STAT = 8'h08;
    localparam logic [ADDR_W-1:0] A_CMD  = 8'h10;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [NCS-1:0]   cs_en;
        logic             cs_late;
        logic             idle_lo;
        logic             three_wire;
        logic             lsb_first;
        logic             cs_high;
    } cfg_t;

    typedef struct packed {
        logic [CS_W-1:0]  cs;
        logic             leave;
        logic [CNT_W-1:0] txn;
        logic [CNT_W-1:0] tot;
    } cmd_t;

    function automatic cfg_t cfg_unpack(logic [DATA_W-1:0] w);
        cfg_t c;
        c.cs_high    = w[0];
        c.lsb_first  = w[1];
        c.three_wire = w[2];
        c.idle_lo    = w[3];
        c.cs_late    = w[4];
        c.cs_en      = w[12 +: NCS];
        c.div        = w[16 +: DIV_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_pack(cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = c.cs_high;
        w[1] = c.lsb_first;
        w[2] = c.three_wire;
        w[3] = c.idle_lo;
        w[4] = c.cs_late;
        w[12 +: NCS]   = c.cs_en;
        w[16 +: DIV_W] = c.div;
        return w;
    endfunction

    function automatic cmd_t cmd_decode(logic [DATA_W-1:0] w);
        cmd_t c;
        logic [CNT_W-1:0] t;
        logic [CNT_W-1:0] x;
        t = w[8 +: CNT_W];
        x = w[4 +: CNT_W];
        c.cs    = w[0 +: CS_W];
        c.leave = w[2];
        c.tot   = (t > CNT_W'(NBYTES)) ? CNT_W'(NBYTES) : t;
        c.txn   = (x > c.tot) ? c.tot : x;
        return c;
    endfunction

endpackage

// File: rtl/spi_buf_regs.sv
module spi_buf_regs
    import spi_buf_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_wen,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic                        busy,
    input  logic                        wb_en,
    input  logic [CNT_W-1:0]            wb_idx,
    input  logic [7:0]                  wb_data,
    output cfg_t                        cfg,
    output logic [NBYTES-1:0][7:0]      buf_q,
    output logic                        start,
    output cmd_t                        cmd,
    output logic                        cs_clear
);

    logic             slot_hit;
    logic [CNT_W-1:0] slot_idx;
    logic             wr_ok;

    assign slot_idx = bus_addr[3 +: CNT_W];
    assign slot_hit = bus_addr[7] && (bus_addr[2:0] == 3'b000) && (slot_idx < CNT_W'(NBYTES));
    assign wr_ok    = bus_wen && !busy;
    assign cmd      = cmd_decode(bus_wdata);
    assign start    = wr_ok && (bus_addr == A_CMD) && (cmd.tot != '0);
    assign cs_clear = wr_ok && (bus_addr == A_CFG) && (bus_wdata == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_ok && bus_addr == A_CFG) begin
            cfg <= cfg_unpack(bus_wdata);
        end
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                buf_q[i] <= '0;
            end else if (wb_en && wb_idx == CNT_W'(i)) begin
                buf_q[i] <= wb_data;
            end else if (wr_ok && slot_hit && slot_idx == CNT_W'(i)) begin
                buf_q[i] <= bus_wdata[7:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CFG) begin
            bus_rdata = cfg_pack(cfg);
        end else if (bus_addr == A_STAT) begin
            bus_rdata[0] = busy;
        end else if (slot_hit) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (slot_idx == CNT_W'(i)) bus_rdata[7:0] = buf_q[i];
            end
        end
    end

endmodule

// File: rtl/spi_buf_engine.sv
module spi_buf_engine
    import spi_buf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [CNT_W-1:0]       cmd_txn,
    input  logic [CNT_W-1:0]       cmd_tot,
    input  logic [DIV_W-1:0]       div,
    input  logic                   lsb_first,
    input  logic                   three_wire,
    input  logic                   idle_lo,
    input  logic                   cs_late,
    input  logic [NBYTES-1:0][7:0] buf_q,
    input  logic                   spi_din,
    input  logic                   spi_dio_in,
    output logic                   busy,
    output logic                   done,
    output logic                   wb_en,
    output logic [CNT_W-1:0]       wb_idx,
    output logic [7:0]             wb_data,
    output logic                   spi_sclk,
    output logic                   spi_dout,
    output logic                   spi_dout_en
);

    logic             busy_q, half_q;
    logic [DIV_W-1:0] cnt_q, div_eff;
    logic [2:0]       bit_q, bitpos;
    logic [CNT_W-1:0] byte_q, txn_q, tot_q;
    logic [7:0]       rx_q, cur_byte;
    logic             tick, byte_end, din, in_tx, lvl;

    assign div_eff  = (div == '0) ? DIV_W'(1) : div;
    assign tick     = busy_q && (cnt_q == div_eff - DIV_W'(1));
    assign bitpos   = lsb_first ? bit_q : 3'd7 - bit_q;
    assign din      = three_wire ? spi_dio_in : spi_din;
    assign byte_end = tick && half_q && (bit_q == 3'd7);
    assign done     = byte_end && (byte_q == tot_q - CNT_W'(1));
    assign in_tx    = byte_q < txn_q;

    always_comb begin
        cur_byte = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (byte_q == CNT_W'(i)) cur_byte = buf_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            half_q <= 1'b0;
            cnt_q  <= '0;
            bit_q  <= '0;
            byte_q <= '0;
            rx_q   <= '0;
            txn_q  <= '0;
            tot_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            half_q <= 1'b0;
            cnt_q  <= '0;
            bit_q  <= '0;
            byte_q <= '0;
            rx_q   <= '0;
            txn_q  <= cmd_txn;
            tot_q  <= cmd_tot;
        end else if (busy_q) begin
            if (tick) begin
                cnt_q  <= '0;
                half_q <= ~half_q;
                if (!half_q) begin
                    rx_q[bitpos] <= din;
                end else begin
                    bit_q <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        byte_q <= byte_q + CNT_W'(1);
                        rx_q   <= '0;
                    end
                    if (done) busy_q <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q + DIV_W'(1);
            end
        end
    end

    assign busy        = busy_q;
    assign wb_en       = byte_end;
    assign wb_idx      = byte_q;
    assign wb_data     = rx_q;
    assign lvl         = ~idle_lo;
    assign spi_sclk    = !busy_q ? lvl : ((half_q ^ cs_late) ? ~lvl : lvl);
    assign spi_dout    = busy_q && in_tx && cur_byte[bitpos];
    assign spi_dout_en = !three_wire || (busy_q && in_tx);

endmodule

// File: rtl/spi_buf_csctl.sv
module spi_buf_csctl
    import spi_buf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [CS_W-1:0] cmd_cs,
    input  logic            cmd_leave,
    input  logic            done,
    input  logic            cs_clear,
    input  logic            cs_high,
    input  logic [NCS-1:0]  cs_en,
    output logic [NCS-1:0]  spi_cs_o,
    output logic [NCS-1:0]  spi_cs_oe
);

    logic            act_q, leave_q;
    logic [CS_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst || cs_clear) begin
            act_q   <= 1'b0;
            leave_q <= 1'b0;
            sel_q   <= '0;
        end else if (start) begin
            act_q   <= 1'b1;
            leave_q <= cmd_leave;
            sel_q   <= cmd_cs;
        end else if (done) begin
            act_q   <= leave_q;
        end
    end

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign spi_cs_o[i] = (act_q && sel_q == CS_W'(i)) ? cs_high : ~cs_high;
    end

    assign spi_cs_oe = cs_en;

endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
    import spi_buf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_sclk,
    output logic              spi_dout,
    output logic              spi_dout_en,
    input  logic              spi_din,
    input  logic              spi_dio_in,
    output logic [NCS-1:0]    spi_cs_o,
    output logic [NCS-1:0]    spi_cs_oe
);

    cfg_t                   cfg;
    cmd_t                   cmd;
    logic [NBYTES-1:0][7:0] buf_q;
    logic                   busy, done, start, cs_clear, wb_en;
    logic [CNT_W-1:0]       wb_idx;
    logic [7:0]             wb_data;

    spi_buf_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .wb_en     (wb_en),
        .wb_idx    (wb_idx),
        .wb_data   (wb_data),
        .cfg       (cfg),
        .buf_q     (buf_q),
        .start     (start),
        .cmd       (cmd),
        .cs_clear  (cs_clear)
    );

    spi_buf_engine u_engine (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .cmd_txn     (cmd.txn),
        .cmd_tot     (cmd.tot),
        .div         (cfg.div),
        .lsb_first   (cfg.lsb_first),
        .three_wire  (cfg.three_wire),
        .idle_lo     (cfg.idle_lo),
        .cs_late     (cfg.cs_late),
        .buf_q       (buf_q),
        .spi_din     (spi_din),
        .spi_dio_in  (spi_dio_in),
        .busy        (busy),
        .done        (done),
        .wb_en       (wb_en),
        .wb_idx      (wb_idx),
        .wb_data     (wb_data),
        .spi_sclk    (spi_sclk),
        .spi_dout    (spi_dout),
        .spi_dout_en (spi_dout_en)
    );

    spi_buf_csctl u_csctl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd_cs    (cmd.cs),
        .cmd_leave (cmd.leave),
        .done      (done),
        .cs_clear  (cs_clear),
        .cs_high   (cfg.cs_high),
        .cs_en     (cfg.cs_en),
        .spi_cs_o  (spi_cs_o),
        .spi_cs_oe (spi_cs_oe)
    );

endmodule

// File: rtl/spi_buf_chk.sv
module spi_buf_chk
    import spi_buf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wen,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              busy,
    input cfg_t              cfg,
    input logic              sclk,
    input logic              dout_en,
    input logic [NCS-1:0]    cs_o,
    input logic [NCS-1:0]    cs_oe
);

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_wen && bus_addr == A_CMD));

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_wen && bus_addr == A_CFG) |=> $stable(cfg));

    // R6
    single_cs_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_oe & (cfg.cs_high ? cs_o : ~cs_o)));

    // R7
    cs_off_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && !busy && bus_addr == A_CFG && bus_wdata == '0) |=> (cs_oe == '0));

    // R8
    line_float_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.three_wire && !busy) |-> !dout_en);

    // R5
    sclk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && $stable(cfg)) |-> $stable(sclk));

endmodule

bind spi_buf_master spi_buf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .cfg       (cfg),
    .sclk      (spi_sclk),
    .dout_en   (spi_dout_en),
    .cs_o      (spi_cs_o),
    .cs_oe     (spi_cs_oe)
);

// File: tb/test_spi_buf_master.sv
module test_spi_buf_master;

    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_dout, spi_dout_en;
    logic        spi_din = 1'b0;
    logic        spi_dio_in = 1'b0;
    logic [3:0]  spi_cs_o, spi_cs_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cap_n = 0;
    bit finished = 0;
    logic [7:0] bmem [9];
    bit   rx_pat [80];
    logic cap_mosi [80];
    logic cap_oe [80];
    logic [3:0] cap_cs [80];
    bit m_lsb, m_late, m_3w, m_idle_lo, m_high;
    int m_div;

    spi_buf_master i_spi_buf_master (
        .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
        .spi_dout(spi_dout), .spi_dout_en(spi_dout_en), .spi_din(spi_din),
        .spi_dio_in(spi_dio_in), .spi_cs_o(spi_cs_o), .spi_cs_oe(spi_cs_oe)
    );

    always #(CLK_PER/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // slave model: records the data line at each sampling transition, then presents the next input bit
    initial begin
        logic prev_sclk, prev_mosi, prev_oe;
        bit lvl, cap;
        prev_sclk = 1'b1; prev_mosi = 1'b0; prev_oe = 1'b0;
        forever begin
            @(negedge clk);
            lvl = !m_idle_lo;
            cap = m_late ? (prev_sclk != lvl && spi_sclk == lvl)
                         : (prev_sclk == lvl && spi_sclk != lvl);
            if (cap && cap_n < 79) begin
                cap_mosi[cap_n] = prev_mosi;
                cap_oe[cap_n]   = prev_oe;
                cap_cs[cap_n]   = spi_cs_o;
                cap_n = cap_n + 1;
            end
            spi_din    = rx_pat[cap_n];
            spi_dio_in = ~rx_pat[cap_n];
            prev_sclk = spi_sclk; prev_mosi = spi_dout; prev_oe = spi_dout_en;
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_cfg(bit high, bit lsb, bit w3, bit ilo, bit late, int div, logic [3:0] en);
        logic [31:0] w;
        w = {3'b0, 13'(div), en, 7'b0, late, ilo, w3, lsb, high};
        wr(8'h00, w);
        m_high = high; m_lsb = lsb; m_3w = w3; m_idle_lo = ilo; m_late = late; m_div = div;
        @(negedge clk);
    endtask

    task automatic fill(int seed);
        for (int i = 0; i < 9; i++) begin
            bmem[i] = 8'((i * 37 + seed * 11 + 5) ^ (seed << 2));
            wr(8'h80 + 8'(8 * i), {24'b0, bmem[i]});
        end
    endtask

    task automatic xfer(int cs, bit leave, int txn, int tot, int seed, bit poke, string req);
        int tot_e, txn_e, deff, t0, dur, bad_tx, bad_cs, bad_oe, k, pos;
        logic [31:0] d;
        logic [7:0] exp_b;
        bit ebit, act;
        tot_e = tot > 9 ? 9 : tot;
        txn_e = txn > tot_e ? tot_e : txn;
        deff = m_div == 0 ? 1 : m_div;
        for (int n = 0; n < 80; n++) rx_pat[n] = ((n * 7 + seed) % 5) < 2;
        @(negedge clk);
        cap_n = 0;
        wr(8'h10, 32'(cs) | (32'(leave) << 2) | (32'(txn) << 4) | (32'(tot) << 8));
        t0 = cyc;
        dur = -1;
        while (cyc - t0 < 20000) begin
            if (poke && cyc - t0 == 5) begin
                wr(8'h10, 32'h0000_0990);
                wr(8'h80 + 8'd64, 32'h0000_005A);
                wr(8'h00, 32'h0);
            end
            rd(8'h08, d);
            if (d[0] == 1'b0) begin dur = cyc - t0; break; end
            @(negedge clk);
        end
        // R2 busy length
        chk(dur == 16 * deff * tot_e, {req, " R2 busy cycles"}, dur, 16 * deff * tot_e);
        chk(cap_n == 8 * tot_e, {req, " R5 clock pulses"}, cap_n, 8 * tot_e);
        bad_tx = 0; bad_cs = 0; bad_oe = 0;
        for (int n = 0; n < 8 * tot_e && n < 79; n++) begin
            k = n % 8;
            ebit = (n / 8 < txn_e) ? bmem[n / 8][m_lsb ? k : 7 - k] : 1'b0;
            if ((n / 8 < txn_e || !m_3w) && cap_mosi[n] !== ebit) bad_tx++;
            if (m_3w && cap_oe[n] !== (n / 8 < txn_e)) bad_oe++;
            if (cap_cs[n][cs] !== m_high) bad_cs++;
        end
        // R3 transmitted bits, order and receive-only level
        chk(bad_tx == 0, {req, " R3 tx bits"}, bad_tx, 0);
        // R6 chip select active during the command
        chk(bad_cs == 0, {req, " R6 cs during"}, bad_cs, 0);
        if (m_3w) chk(bad_oe == 0, {req, " R8 line enable"}, bad_oe, 0);
        for (int i = 0; i < tot_e; i++) begin
            exp_b = '0;
            for (int b = 0; b < 8; b++) begin
                pos = m_lsb ? b : 7 - b;
                exp_b[pos] = rx_pat[8 * i + b] ^ m_3w;
            end
            bmem[i] = exp_b;
            rd(8'h80 + 8'(8 * i), d);
            // R4 received byte lands in its own slot
            chk(d[7:0] == exp_b, {req, " R4 rx slot"}, int'(d[7:0]), int'(exp_b));
        end
        act = leave ? m_high : !m_high;
        chk(spi_cs_o[cs] == act, {req, " R6 cs after"}, int'(spi_cs_o[cs]), int'(act));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h08, d);
        chk(d == 0, "R2 reset busy", int'(d), 0);
        chk(spi_cs_oe == 4'h0, "R7 reset cs enables", int'(spi_cs_oe), 0);
        chk(spi_sclk == 1'b1, "R5 reset sclk idle", int'(spi_sclk), 1);
        rd(8'h00, d);
        chk(d == 0, "R1 reset cfg", int'(d), 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        set_cfg(0, 1, 0, 0, 1, 5, 4'b1010);
        rd(8'h00, d);
        chk(d == 32'h0005_A012, "R1 cfg readback", int'(d), 32'h0005_A012);
        chk(spi_cs_oe == 4'b1010, "R7 enables follow cfg", int'(spi_cs_oe), 4'b1010);
        fill(3);
        rd(8'h80 + 8'd40, d);
        chk(d == {24'b0, bmem[5]}, "R1 slot readback", int'(d), int'(bmem[5]));
        rd(8'h84, d);
        chk(d == 0, "R1 unmapped read", int'(d), 0);
    endtask

    task automatic t_basic();
        set_cfg(0, 0, 0, 0, 0, 2, 4'hF);
        fill(1);
        xfer(0, 0, 2, 3, 4, 0, "basic");
    endtask

    task automatic t_lsb_late();
        set_cfg(0, 1, 0, 0, 1, 3, 4'hF);
        fill(2);
        xfer(2, 0, 3, 3, 9, 0, "lsb late");
    endtask

    task automatic t_idle_low();
        set_cfg(0, 0, 0, 1, 0, 1, 4'hF);
        chk(spi_sclk == 1'b0, "R5 idle low", int'(spi_sclk), 0);
        fill(5);
        xfer(1, 0, 1, 2, 2, 0, "idle low");
        set_cfg(0, 0, 0, 1, 1, 2, 4'hF);
        xfer(3, 0, 2, 2, 6, 0, "idle low late");
    endtask

    task automatic t_div0();
        set_cfg(0, 0, 0, 0, 0, 0, 4'hF);
        fill(6);
        xfer(0, 0, 1, 1, 1, 0, "div zero");
    endtask

    task automatic t_hold();
        set_cfg(1, 0, 0, 0, 0, 1, 4'hF);
        fill(7);
        chk(spi_cs_o == 4'h0, "R6 active-high idle", int'(spi_cs_o), 0);
        xfer(3, 1, 1, 1, 3, 0, "hold");
        xfer(3, 0, 0, 1, 8, 0, "release");
    endtask

    task automatic t_cfg_zero();
        set_cfg(0, 0, 0, 0, 0, 1, 4'hF);
        xfer(1, 1, 1, 1, 5, 0, "hold low");
        wr(8'h00, 32'h0);
        chk(spi_cs_oe == 4'h0, "R7 zero cfg enables", int'(spi_cs_oe), 0);
        set_cfg(0, 0, 0, 0, 0, 1, 4'hF);
        chk(spi_cs_o[1] == 1'b1, "R7 zero cfg drops hold", int'(spi_cs_o[1]), 1);
    endtask

    task automatic t_3wire();
        set_cfg(0, 0, 1, 0, 0, 1, 4'hF);
        chk(spi_dout_en == 1'b0, "R8 idle float", int'(spi_dout_en), 0);
        fill(8);
        xfer(2, 0, 2, 4, 7, 0, "three wire");
    endtask

    task automatic t_busy_ignore();
        logic [31:0] d;
        set_cfg(0, 0, 0, 0, 0, 2, 4'hF);
        fill(9);
        xfer(0, 0, 2, 2, 3, 1, "busy poke R9");
        rd(8'h80 + 8'd64, d);
        chk(d[7:0] == bmem[8], "R9 slot write ignored", int'(d[7:0]), int'(bmem[8]));
        rd(8'h00, d);
        chk(d == 32'h0002_F000, "R9 cfg write ignored", int'(d), 32'h0002_F000);
    endtask

    task automatic t_clamp();
        logic [31:0] d;
        set_cfg(0, 0, 0, 0, 0, 1, 4'hF);
        fill(4);
        xfer(1, 0, 15, 15, 2, 0, "R10 total clamp");
        fill(10);
        xfer(2, 0, 7, 2, 4, 0, "R10 tx clamp");
        wr(8'h10, 32'h0000_0030);
        rd(8'h08, d);
        chk(d == 0, "R10 zero total ignored", int'(d), 0);
    endtask

    initial begin
        m_idle_lo = 0; m_late = 0; m_lsb = 0; m_3w = 0; m_high = 0; m_div = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_basic();
        t_lsb_late();
        t_idle_low();
        t_div0();
        t_hold();
        t_cfg_zero();
        t_3wire();
        t_busy_ignore();
        t_clamp();
        report();
    end

endmodule